// File: doc/BRIEF.md
# Two-Way Parallel-Lookup Read Cache

This block is a 4 KB read-only cache with two ways. Both address and tag are virtual, and lines are 64 bytes. The core sends a 32-bit address. The block then reads the two tags of the addressed set and the two candidate 32-bit words in one cycle. It compares both tags against the address and returns the word from the way that matches. The data store keeps the two ways' words for one index next to each other in a 64-bit row, so that a single row read yields every candidate.

On a miss, the block sends one line-aligned request toward the next level and takes sixteen 32-bit beats. It writes those beats into the way that the set's single-bit least-recently-used flag chose as victim, then returns the word that was asked for. A flush input invalidates the whole cache, one set per cycle. Writes, coherence and address translation are not part of this block.

Top module: `vivt_cache2w`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `fill_req_valid` is 0, and every line is invalid.
- R2: A miss raises `fill_req_valid` with `fill_req_addr` = {address[31:6], 6'b0}. Both stay unchanged until `fill_req_ready` is seen high at a clock edge, and the miss produces exactly one such request.
- R3: After the sixteenth fill beat, `rsp_valid` is high in the next cycle for exactly one cycle. `rsp_data` then holds the beat whose number equals address bits [5:2]. Beats arrive in word order 0..15.
- R4: A hit to a valid line raises `rsp_valid` two cycles after the request is driven (one clock edge after acceptance), with no fill request. The data comes from the way whose tag matches.
- R5: The set index is address bits [10:6]. The tag is bits [31:11], so two lines that differ only in bit 11 occupy both ways of one set and can both hit.
- R6: A hit requires that way's valid bit and an equal tag. At most one way matches on any lookup.
- R7: A miss replaces the least-recently-used way of its set. Every hit and every fill makes the touched way the most recently used.
- R8: `req_ready` is low from the edge that accepts a request until that request's response has been produced.
- R9: A one-cycle `flush` pulse taken while idle holds `req_ready` low for exactly 32 cycles. Afterwards every earlier line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate-all request |
| req_valid | input | 1 | Core read request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | 32 | Byte address of the read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Read word |
| fill_req_valid | output | 1 | Line request toward next level |
| fill_req_ready | input | 1 | Next level accepts the line request |
| fill_req_addr | output | 32 | Line-aligned request address |
| fill_valid | input | 1 | Fill beat valid |
| fill_data | input | 32 | Fill beat data |

## Verification
The assertions assume two things about the next level. It drives `fill_valid` only after the line request has been accepted, and it delivers exactly sixteen beats per request. They also assume `flush` arrives while the cache is idle or is left to wait. The bench keeps to these assumptions: its responder acts only when it sees `fill_req_valid` and accepts that request once. It sends sixteen beats in word order and pulses `flush` only between accesses. The access table walks one set through fills, hits in both ways and LRU evictions. It then crosses into other sets with the highest and arbitrary tags.

// File: rtl/vivt_cache2w.sv
module vivt_cache2w #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fill_req_valid,
  input  logic              fill_req_ready,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WOFF_W = OFF_W - BYTE_W;
  localparam int BEATS  = LINE_BYTES / (DATA_W / 8);
  localparam int ROWS   = SETS * BEATS;
  localparam int ROW_W  = IDX_W + WOFF_W;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_REQ, S_FILL, S_FLUSH} st_t;

  st_t                state;
  logic [ADDR_W-1:0]  q_addr;
  logic [1:0]         vld [SETS];
  logic [SETS-1:0]    lru;
  logic [TAG_W-1:0]   tag_mem [SETS][2];
  logic [2*DATA_W-1:0] data_mem [ROWS];
  logic [WOFF_W-1:0]  beat;
  logic [IDX_W-1:0]   fcnt;
  logic               victim;
  logic               flush_pend;

  wire [TAG_W-1:0]  q_tag  = q_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0]  q_idx  = q_addr[OFF_W +: IDX_W];
  wire [WOFF_W-1:0] q_woff = q_addr[BYTE_W +: WOFF_W];
  wire [ROW_W-1:0]  rd_row = {q_idx, q_woff};
  wire [ROW_W-1:0]  wr_row = {q_idx, beat};

  logic [1:0] hit;
  for (genvar w = 0; w < 2; w++) begin : g_way
    assign hit[w] = vld[q_idx][w] && (tag_mem[q_idx][w] == q_tag);
  end

  wire [2*DATA_W-1:0] rd_pair  = data_mem[rd_row];
  wire [DATA_W-1:0]   hit_word = hit[1] ? rd_pair[2*DATA_W-1:DATA_W] : rd_pair[DATA_W-1:0];
  wire                last_beat = (state == S_FILL) && fill_valid && (beat == WOFF_W'(BEATS - 1));

  assign req_ready      = (state == S_IDLE) && !flush && !flush_pend;
  assign fill_req_valid = (state == S_REQ);
  assign fill_req_addr  = {q_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      q_addr     <= '0;
      lru        <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      beat       <= '0;
      fcnt       <= '0;
      victim     <= 1'b0;
      flush_pend <= 1'b0;
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (flush && state != S_IDLE) flush_pend <= 1'b1;
      case (state)
        S_IDLE: begin
          if (flush || flush_pend) begin
            state      <= S_FLUSH;
            fcnt       <= '0;
            flush_pend <= 1'b0;
          end else if (req_valid) begin
            q_addr <= req_addr;
            state  <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (|hit) begin
            rsp_valid  <= 1'b1;
            rsp_data   <= hit_word;
            lru[q_idx] <= !hit[1];
            state      <= S_IDLE;
          end else begin
            victim <= lru[q_idx];
            state  <= S_REQ;
          end
        end
        S_REQ: begin
          if (fill_req_ready) begin
            beat  <= '0;
            state <= S_FILL;
          end
        end
        S_FILL: begin
          if (fill_valid) begin
            beat <= beat + 1'b1;
            if (beat == q_woff) rsp_data <= fill_data;
            if (last_beat) begin
              vld[q_idx][victim] <= 1'b1;
              lru[q_idx]         <= !victim;
              rsp_valid          <= 1'b1;
              state              <= S_IDLE;
            end
          end
        end
        S_FLUSH: begin
          vld[fcnt] <= '0;
          lru[fcnt] <= 1'b0;
          fcnt      <= fcnt + 1'b1;
          if (fcnt == IDX_W'(SETS - 1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_FILL && fill_valid) begin
      if (victim) data_mem[wr_row][2*DATA_W-1:DATA_W] <= fill_data;
      else        data_mem[wr_row][DATA_W-1:0]        <= fill_data;
    end
    if (last_beat) tag_mem[q_idx][victim] <= q_tag;
  end

  logic any_vld;
  always_comb begin
    any_vld = 1'b0;
    for (int s = 0; s < SETS; s++) any_vld = any_vld | (|vld[s]);
  end

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid && !fill_req_ready |=> fill_req_valid && $stable(fill_req_addr));
  a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r6_one_match: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_LOOK |-> $onehot0(hit));
  a_r7_fill_mru: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> lru[$past(q_idx)] != $past(victim));
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_FLUSH && fcnt == IDX_W'(SETS - 1) |=> !any_vld);
endmodule

// File: tb/vivt_cache2w_bench.sv
`timescale 1ns/1ps
module vivt_cache2w_bench;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic req_valid = 1'b0, fill_req_ready = 1'b0, fill_valid = 1'b0;
  logic [31:0] req_addr = '0, fill_data = '0;
  logic req_ready, rsp_valid, fill_req_valid;
  logic [31:0] rsp_data, fill_req_addr;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  vivt_cache2w u_vivt_cache2w (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_req_addr(fill_req_addr), .fill_valid(fill_valid), .fill_data(fill_data));

  function automatic logic [31:0] model(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3A5_5A3C;
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // {expect_miss, address}: one set walked through fills, hits and LRU evictions
  localparam logic [32:0] VEC [13] = '{
    {1'b1, 32'h0000_0040}, {1'b0, 32'h0000_0044}, {1'b1, 32'h0000_0840},
    {1'b0, 32'h0000_087C}, {1'b0, 32'h0000_0040}, {1'b1, 32'h0000_1040},
    {1'b1, 32'h0000_0840}, {1'b0, 32'h0000_1040}, {1'b1, 32'h0000_0040},
    {1'b1, 32'hFFFF_FFFC}, {1'b0, 32'hFFFF_FFC0}, {1'b1, 32'h1234_5678},
    {1'b0, 32'h1234_5640}};

  task automatic access(input logic [31:0] a, input bit exp_miss);
    int lat, served;
    @(negedge clk);
    req_addr = a; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; lat = 1; served = 0;
    chk(!req_ready, "R8 ready low while busy", {31'b0, req_ready}, 32'd0);
    while (!rsp_valid && lat < 200) begin
      if (fill_req_valid && served == 0) begin
        chk(fill_req_addr == {a[31:6], 6'b0}, "R2 line address", fill_req_addr, {a[31:6], 6'b0});
        @(negedge clk); lat++;
        chk(fill_req_valid && fill_req_addr == {a[31:6], 6'b0}, "R2 request held",
            fill_req_addr, {a[31:6], 6'b0});
        fill_req_ready = 1'b1;
        @(negedge clk); lat++;
        fill_req_ready = 1'b0;
        for (int b = 0; b < 16; b++) begin
          fill_valid = 1'b1;
          fill_data  = model({a[31:6], 4'(b), 2'b00});
          @(negedge clk); lat++;
        end
        fill_valid = 1'b0; served = 1;
        chk(rsp_valid, "R3 response right after last beat", {31'b0, rsp_valid}, 32'd1);
      end else begin
        @(negedge clk); lat++;
      end
    end
    if (exp_miss) chk(served == 1, "R2/R7 miss fetched one line", served, 1);
    else begin
      chk(served == 0, "R4/R5 hit without fill", served, 0);
      chk(lat == 2, "R4 hit latency", lat, 2);
    end
    chk(rsp_data == model(a), exp_miss ? "R3 fill word" : "R6 hit word", rsp_data, model(a));
    @(negedge clk);
    chk(!rsp_valid && !fill_req_valid, "R3 single-cycle response", {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #(5 * 20000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int low;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !fill_req_valid, "R1 reset outputs",
        {29'b0, req_ready, rsp_valid, fill_req_valid}, 32'd4);
    foreach (VEC[i]) access(VEC[i][31:0], VEC[i][32]);
    // R9: flush timing and invalidation
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    low = 0;
    while (!req_ready && low < 100) begin
      low++;
      @(negedge clk);
    end
    chk(low == 32, "R9 flush busy cycles", low, 32);
    access(32'h0000_1040, 1'b1);
    access(32'hFFFF_FFC0, 1'b1);
    access(32'h1234_5644, 1'b1);
    access(32'h0000_1044, 1'b0);
    // R1: reset mid-run invalidates
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !fill_req_valid, "R1 reset outputs again",
        {29'b0, req_ready, rsp_valid, fill_req_valid}, 32'd4);
    access(32'h0000_1040, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule